// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block holds the bytes that a host moves one at a time through a single data register of a storage controller. A host write lands in one of two places. While the controller is waiting for command bytes, the write goes to a separate command buffer. Otherwise the write goes into a circular data FIFO. That FIFO declares overrun one entry before it is physically full. A host read pops the oldest byte and pulses an interrupt. The number of stored bytes is always visible on a port.

When the FIFO drains to empty through a read, both internal pointers return to slot zero. In a data-out phase a read returns zero and consumes a count without moving the read pointer, so this reset is visible in the order of later data. A flush input discards all data in one cycle. The command buffer can be read back by index for the logic that decodes the command.

Top module: `pio_fifo`

## Requirements
- R1: While `cmdPending` is 1, an accepted write stores its low byte at command buffer index `cmdLen`, and `cmdLen` increments on the next cycle. `count` stays unchanged.
- R2: The command buffer holds CMD_DEPTH bytes (default 32). A command write made when `cmdLen` equals CMD_DEPTH is dropped and `cmdLen` stays at CMD_DEPTH.
- R3: While `cmdPending` is 0, an accepted write appends its low byte to the data FIFO and `count` increments. When `count` equals DEPTH-1 (default 15), the write is dropped, `count` is unchanged, and `overrun` is 1 for exactly the following cycle.
- R4: An accepted read with `count` nonzero decrements `count`. One cycle later `rdData` holds the oldest stored byte, in first-in first-out order, and `rdIrq` is 1 for that one cycle.
- R5: An accepted read with `count` zero has no effect: `rdData` keeps its value, `count` stays 0, and `rdIrq` stays 0.
- R6: A read made with `dataOutPhase` 1 and `count` nonzero yields `rdData` = 0. It decrements `count` and pulses `rdIrq`, but leaves the read pointer where it was.
- R7: Whenever a read brings `count` to zero, both the read and write pointers return to slot 0. The next written byte is therefore the next byte read.
- R8: A write is accepted only when `wrSize` is 1 or 4 (a byte count; only bits 7:0 of `wrData` are kept). A read is accepted only when `rdSize` is 1. Any other size leaves the block unchanged.
- R9: `flush` = 1 sets `count` to 0 on the next cycle and resets both pointers. Bytes written afterwards are read back first. `flush` takes priority over a write or read in the same cycle.
- R10: After reset, `count`, `cmdLen`, `rdData`, `rdIrq` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all data FIFO contents |
| cmdPending | input | 1 | Steer writes into the command buffer |
| dataOutPhase | input | 1 | Bus is in data-out phase; reads return zero |
| wrEn | input | 1 | Host write strobe |
| wrSize | input | 3 | Write access size in bytes |
| wrData | input | 32 | Write data; low byte used |
| rdEn | input | 1 | Host read strobe |
| rdSize | input | 3 | Read access size in bytes |
| rdData | output | 8 | Last popped byte |
| rdIrq | output | 1 | One-cycle pulse after each pop |
| overrun | output | 1 | One-cycle pulse after a dropped data write |
| count | output | CNT_W | Bytes held in the data FIFO |
| cmdLen | output | CMD_LW | Bytes held in the command buffer |
| cmdRdIdx | input | CMD_IW | Command buffer read index |
| cmdRdData | output | 8 | Command byte at `cmdRdIdx` |

## Verification
The bench fills the FIFO to DEPTH-1 and then writes once more. A design that compared against DEPTH instead would accept a sixteenth byte and never pulse `overrun`. It reads in data-out phase and then drains to empty. A design that skipped the pointer reset, or advanced the read pointer on the zero read, would return a stale byte after the refill. It also sends writes and reads with rejected access sizes, reads from an empty FIFO, overfills the command buffer, and flushes with data still inside. A design that got these wrong would change `count`, pulse `rdIrq`, or return discarded data.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
  typedef struct packed {
    logic push;      // store a data byte
    logic pop;       // consume a data byte
    logic popZero;   // consumed byte reads as zero, read pointer holds
    logic cmdPush;   // store a command byte
    logic clrPtrs;   // return both pointers to slot 0
  } fifoStrobes_t;
endpackage

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CMD_DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CMD_LW = $clog2(CMD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              cmdPending,
  input  logic              dataOutPhase,
  input  logic              wrEn,
  input  logic [2:0]        wrSize,
  input  logic              rdEn,
  input  logic [2:0]        rdSize,
  output fifoStrobes_t      strobes,
  output logic [CNT_W-1:0]  count,
  output logic [CMD_LW-1:0] cmdLen,
  output logic              rdIrq,
  output logic              overrun
);
  localparam logic [CNT_W-1:0] FULL_MARK = CNT_W'(DEPTH - 1);
  localparam logic [CMD_LW-1:0] CMD_MAX = CMD_LW'(CMD_DEPTH);

  logic wrOk, rdOk, dataWr, dropWr;

  always_comb begin
    wrOk   = wrEn && (wrSize == 3'd1 || wrSize == 3'd4);
    rdOk   = rdEn && (rdSize == 3'd1);
    dataWr = wrOk && !cmdPending && !flush;
    dropWr = dataWr && (count == FULL_MARK);
    strobes.cmdPush = wrOk && cmdPending && (cmdLen != CMD_MAX);
    strobes.push    = dataWr && !dropWr;
    strobes.pop     = rdOk && !flush && (count != '0);
    strobes.popZero = strobes.pop && dataOutPhase;
    strobes.clrPtrs = flush ||
                      (strobes.pop && !strobes.push && count == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      cmdLen  <= '0;
      rdIrq   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      rdIrq   <= strobes.pop;
      overrun <= dropWr;
      if (strobes.cmdPush) cmdLen <= cmdLen + 1'b1;
      if (flush) count <= '0;
      else count <= count + CNT_W'(strobes.push) - CNT_W'(strobes.pop);
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_MARK);
  assert_overrun_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(count) == FULL_MARK);
  assert_irq_nonempty_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdIrq |-> $past(count) != '0);
  assert_cmd_no_data_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPending && wrEn && !rdEn && !flush) |=> $stable(count));
  assert_cmd_sat_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdLen <= CMD_MAX);
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> count == '0);
endmodule

// File: rtl/pio_fifo_dp.sv
module pio_fifo_dp
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CMD_DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CMD_IW = $clog2(CMD_DEPTH),
  localparam int CMD_LW = $clog2(CMD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [7:0]        wrByte,
  input  logic [CMD_LW-1:0] cmdLen,
  input  logic [CMD_IW-1:0] cmdRdIdx,
  output logic [7:0]        cmdRdData,
  output logic [7:0]        rdData,
  output logic [PTR_W-1:0]  rdPtr,
  output logic [PTR_W-1:0]  wrPtr
);
  logic [7:0] dataMem [DEPTH];
  logic [7:0] cmdMem [CMD_DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.push) dataMem[wrPtr] <= wrByte;
    if (strobes.cmdPush) cmdMem[cmdLen[CMD_IW-1:0]] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strobes.pop) rdData <= strobes.popZero ? 8'h00 : dataMem[rdPtr];
      if (strobes.clrPtrs) begin
        rdPtr <= '0;
        wrPtr <= '0;
      end else begin
        if (strobes.pop && !strobes.popZero) rdPtr <= rdPtr + 1'b1;
        if (strobes.push) wrPtr <= wrPtr + 1'b1;
      end
    end
  end

  assign cmdRdData = cmdMem[cmdRdIdx];

  assert_zero_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.popZero |=> rdData == 8'h00);
endmodule

// File: rtl/pio_fifo.sv
module pio_fifo
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CMD_DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CMD_IW = $clog2(CMD_DEPTH),
  localparam int CMD_LW = $clog2(CMD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              cmdPending,
  input  logic              dataOutPhase,
  input  logic              wrEn,
  input  logic [2:0]        wrSize,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  input  logic [2:0]        rdSize,
  output logic [7:0]        rdData,
  output logic              rdIrq,
  output logic              overrun,
  output logic [CNT_W-1:0]  count,
  output logic [CMD_LW-1:0] cmdLen,
  input  logic [CMD_IW-1:0] cmdRdIdx,
  output logic [7:0]        cmdRdData
);
  fifoStrobes_t strobes;
  logic [PTR_W-1:0] rdPtr, wrPtr;

  pio_fifo_ctrl #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .cmdPending(cmdPending),
    .dataOutPhase(dataOutPhase), .wrEn(wrEn), .wrSize(wrSize),
    .rdEn(rdEn), .rdSize(rdSize), .strobes(strobes), .count(count),
    .cmdLen(cmdLen), .rdIrq(rdIrq), .overrun(overrun));

  pio_fifo_dp #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrByte(wrData[7:0]),
    .cmdLen(cmdLen), .cmdRdIdx(cmdRdIdx), .cmdRdData(cmdRdData),
    .rdData(rdData), .rdPtr(rdPtr), .wrPtr(wrPtr));

  // An empty FIFO has both pointers back at slot 0.
  assert_empty_ptrs_R7: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> (rdPtr == '0 && wrPtr == '0));
endmodule

// File: tb/pio_fifo_bench.sv
`timescale 1ns/1ps
module pio_fifo_bench;
  localparam int DEPTH = 16;
  localparam int CMD_DEPTH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 0, cmdPending = 0, dataOutPhase = 0, wrEn = 0, rdEn = 0;
  logic [2:0] wrSize = 3'd1, rdSize = 3'd1;
  logic [31:0] wrData = '0;
  logic [7:0] rdData, cmdRdData;
  logic rdIrq, overrun;
  logic [4:0] count;
  logic [5:0] cmdLen;
  logic [4:0] cmdRdIdx = '0;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  bit done = 0;

  always #10 clk = ~clk;

  pio_fifo #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_pio_fifo (
    .clk(clk), .rstN(rstN), .flush(flush), .cmdPending(cmdPending),
    .dataOutPhase(dataOutPhase), .wrEn(wrEn), .wrSize(wrSize),
    .wrData(wrData), .rdEn(rdEn), .rdSize(rdSize), .rdData(rdData),
    .rdIrq(rdIrq), .overrun(overrun), .count(count), .cmdLen(cmdLen),
    .cmdRdIdx(cmdRdIdx), .cmdRdData(cmdRdData));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input logic [2:0] sz);
    @(negedge clk);
    wrEn = 1; wrData = d; wrSize = sz;
    @(negedge clk);
    wrEn = 0; wrSize = 3'd1;
  endtask

  // Pushes the expected byte when a pop is predicted.
  task automatic doRead(input logic [2:0] sz, input bit expectPop, input logic [7:0] exp);
    if (expectPop) expQ.push_back(exp);
    @(negedge clk);
    rdEn = 1; rdSize = sz;
    @(negedge clk);
    rdEn = 0; rdSize = 3'd1;
  endtask

  // Monitor: every read pulse is matched against the scoreboard (R4).
  always @(negedge clk) begin
    if (rstN && rdIrq) begin
      if (expQ.size() == 0) check("R4 unexpected pop", 1, 0);
      else check("R4 popped byte", rdData, expQ.pop_front());
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R10 count", count, 0);
    check("R10 cmdLen", cmdLen, 0);
    check("R10 rdData", rdData, 0);
    check("R10 rdIrq", rdIrq, 0);
    check("R10 overrun", overrun, 0);

    // R3/R4 basic order
    doWrite(32'h11, 3'd1); doWrite(32'h22, 3'd1); doWrite(32'h33, 3'd1);
    check("R3 count after writes", count, 3);
    doRead(3'd1, 1, 8'h11); doRead(3'd1, 1, 8'h22); doRead(3'd1, 1, 8'h33);
    check("R4 count drained", count, 0);

    // R5 empty read
    doRead(3'd1, 0, 8'h00);
    check("R5 no irq", rdIrq, 0);
    check("R5 rdData held", rdData, 8'h33);
    check("R5 count", count, 0);

    // R3 overrun one before full
    for (int i = 0; i < DEPTH - 1; i++) doWrite(32'hA0 + i, 3'd1);
    check("R3 count at mark", count, DEPTH - 1);
    check("R3 no overrun yet", overrun, 0);
    doWrite(32'hEE, 3'd1);
    check("R3 overrun pulse", overrun, 1);
    check("R3 count held", count, DEPTH - 1);
    @(negedge clk);
    check("R3 overrun one cycle", overrun, 0);
    for (int i = 0; i < DEPTH - 1; i++) doRead(3'd1, 1, 8'hA0 + i);
    check("R3 drained", count, 0);

    // R8 access sizes
    doWrite(32'hAABBCC5A, 3'd4);
    check("R8 word write accepted", count, 1);
    doWrite(32'h66, 3'd2);
    check("R8 half write ignored", count, 1);
    doRead(3'd4, 0, 8'h00);
    check("R8 word read ignored irq", rdIrq, 0);
    check("R8 word read ignored count", count, 1);
    doRead(3'd1, 1, 8'h5A);
    check("R8 byte read", count, 0);

    // R6/R7 data-out read and pointer reset
    doWrite(32'h41, 3'd1); doWrite(32'h42, 3'd1);
    dataOutPhase = 1;
    doRead(3'd1, 1, 8'h00);
    check("R6 zero read irq", rdIrq, 1);
    check("R6 count", count, 1);
    dataOutPhase = 0;
    doRead(3'd1, 1, 8'h41);
    check("R7 empty", count, 0);
    doWrite(32'h43, 3'd1);
    doRead(3'd1, 1, 8'h43);

    // R1/R2 command capture
    cmdPending = 1;
    for (int i = 0; i < CMD_DEPTH + 1; i++) doWrite(32'h40 + i, 3'd1);
    cmdPending = 0;
    check("R1 data count untouched", count, 0);
    check("R2 cmdLen saturates", cmdLen, CMD_DEPTH);
    cmdRdIdx = 5'd0; #1;
    check("R1 cmd byte 0", cmdRdData, 8'h40);
    cmdRdIdx = 5'd31; #1;
    check("R2 cmd last byte", cmdRdData, 8'h40 + 31);

    // R9 flush
    doWrite(32'h91, 3'd1); doWrite(32'h92, 3'd1); doWrite(32'h93, 3'd1);
    doRead(3'd1, 1, 8'h91);
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    check("R9 flushed count", count, 0);
    doWrite(32'h77, 3'd1);
    doRead(3'd1, 1, 8'h77);

    @(negedge clk);
    check("R4 scoreboard empty", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule